// File: doc/BRIEF.md
# Interrupt Pending and Masking Core

This block keeps the pending state of a small interrupt controller for up to 64 sources. Peripherals pend a source with a one-cycle pulse request or with an indexed level command (line goes high or low). The block records every pend in a pre-mask vector and, when the source's enable bit is set, also in a status vector. A separate priority resolver reads the status vector. The block drives a single CPU wake request.

Software changes the block through indexed commands. It can enable or disable a source, clear one source, clear everything or only the enabled sources, set or release a global lock, and re-pend a level source when its handler exits. While the lock is set, pends are still recorded but no wake is issued. One reserved index acts as a hard request that lets exactly one wake through the lock.

Within a cycle the inputs are applied in a fixed order. A pulse scheduled in an earlier cycle fires first. Then the command is applied, then the level command, then the pulse raise, and last the immediate raise.

Top module: `irq_pend_core`

## Requirements
- R1: A raise on an in-range source always sets its bit in `pend_o`. It sets the bit in `status_o` only if the source's bit in `enable_o` is set. A status bit is never set without its pend bit.
- R2: Command op 1 (enable) sets the enable bit. If the source's pend bit is already set, the same command also sets its status bit, and `wake_o` is high in that same cycle when the lock is clear.
- R3: Command op 6 sets the lock to `cmd_idx[0]`. While the lock is set, raises still update both vectors but give no wake, and an enable of a pended source gives no wake. Releasing the lock while `status_o` is nonzero raises `wake_o` in the cycle of the command.
- R4: When the lock is clear, a raise wakes the CPU even if the source is disabled. A pulse raise (`raise_vld`) gives a one-cycle `wake_o` in the cycle after the request. An immediate raise (`raise_now_vld`) gives `wake_o` in the same cycle.
- R5: Command op 3 clears the source's bit in both `status_o` and `pend_o`.
- R6: Command op 4 zeroes `status_o` and clears the `pend_o` bits whose enable bit is set. Command op 5 zeroes both vectors.
- R7: A level command with `lvl_up`=1 pends its source only when the line was low before. Raising a line that is already high changes nothing. A level command with `lvl_up`=0 only lowers the stored line.
- R8: Command op 7 (handler exit) sets the source's pend bit if its stored line is high. It also sets the status bit if the source is enabled. If the line is low, nothing changes.
- R9: A raise on index `HARD_IDX` (default 127) sets a one-shot bypass. The next wake produced by a raise passes even while the lock is set, and the bypass then clears.
- R10: After reset, `enable_o`, `pend_o`, `status_o`, `lock_o`, `wake_o` and `lvl_err_o` are all 0.
- R11: Any index at or above `NUM_SRC` is ignored, except `HARD_IDX` on the raise inputs. A level command on such an index sets `lvl_err_o` for the following cycle.
- R12: Command op 2 (disable) clears only the enable bit. Both pending vectors keep their value. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_vld | input | 1 | Pulse raise request; its wake follows one cycle later |
| raise_idx | input | IDX_W | Source index of the pulse raise |
| raise_now_vld | input | 1 | Immediate raise request; its wake comes in the same cycle |
| raise_now_idx | input | IDX_W | Source index of the immediate raise |
| lvl_vld | input | 1 | Level line command valid |
| lvl_up | input | 1 | 1 raises the line, 0 lowers it |
| lvl_idx | input | IDX_W | Source index of the level command |
| cmd_vld | input | 1 | Software command valid |
| cmd_op | input | 3 | Command opcode (0 nop, 1 enable, 2 disable, 3 clear one, 4 clear enabled, 5 clear all, 6 lock, 7 re-evaluate) |
| cmd_idx | input | IDX_W | Command source index; bit 0 carries the lock value for op 6 |
| enable_o | output | NUM_SRC | Enable mask |
| pend_o | output | NUM_SRC | Pre-mask pending vector |
| status_o | output | NUM_SRC | Masked pending vector for the priority resolver |
| lock_o | output | 1 | Global lock state |
| wake_o | output | 1 | CPU wake request |
| lvl_err_o | output | 1 | Out-of-range level command seen in the previous cycle |

## Verification
The hardest state to reach is the bypass that lets a locked wake through. The stimulus first sets the lock and confirms that an ordinary raise stays silent. It then issues a hard pulse raise, checks the single wake in the next cycle, and shows that a later raise is again blocked. A hard immediate raise is also sent under the lock. The level-line cases need a stored high line whose pend has been cleared by software, so the stimulus raises a line, clears the source, repeats the raise, and then issues the handler-exit command. A behavioural model is compared with every output on every cycle. This includes one cycle that combines a command with a raise, which exercises the fixed ordering of inputs within a cycle.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_EN     = 3'd1,
        OP_DIS    = 3'd2,
        OP_CLR1   = 3'd3,
        OP_CLREN  = 3'd4,
        OP_CLRALL = 3'd5,
        OP_LOCK   = 3'd6,
        OP_REEVAL = 3'd7
    } irq_op_e;
endpackage

// File: rtl/irq_idx_dec.sv
module irq_idx_dec #(
    parameter int NUM_SRC = 64,
    parameter int IDX_W   = 7
) (
    input  logic               vld,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] sel,
    output logic               in_rng
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_SRC);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
        assign sel[i] = vld && ({1'b0, idx} == (IDX_W+1)'(i));
    end

    assign in_rng = vld && ({1'b0, idx} < LIMIT);
endmodule

// File: rtl/irq_line_edge.sv
module irq_line_edge #(
    parameter int NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] line_q,
    input  logic [NUM_SRC-1:0] sel,
    input  logic               up,
    output logic [NUM_SRC-1:0] line_nxt,
    output logic               rise
);
    always_comb begin
        rise     = up && |(sel & ~line_q);
        line_nxt = up ? (line_q | sel) : (line_q & ~sel);
    end
endmodule

// File: rtl/irq_pend_core.sv
module irq_pend_core
    import irq_pend_pkg::*;
#(
    parameter int NUM_SRC  = 64,
    parameter int IDX_W    = 7,
    parameter int HARD_IDX = 127
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               raise_vld,
    input  logic [IDX_W-1:0]   raise_idx,
    input  logic               raise_now_vld,
    input  logic [IDX_W-1:0]   raise_now_idx,
    input  logic               lvl_vld,
    input  logic               lvl_up,
    input  logic [IDX_W-1:0]   lvl_idx,
    input  logic               cmd_vld,
    input  logic [2:0]         cmd_op,
    input  logic [IDX_W-1:0]   cmd_idx,
    output logic [NUM_SRC-1:0] enable_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] status_o,
    output logic               lock_o,
    output logic               wake_o,
    output logic               lvl_err_o
);
    localparam logic [IDX_W-1:0] HARD_SEL = IDX_W'(HARD_IDX);

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] stat;
        logic [NUM_SRC-1:0] line;
        logic               lock;
        logic               bypass;
        logic               sched;
        logic               err;
    } core_st_t;

    core_st_t st_q, st_d;
    logic     wake_d;

    logic [NUM_SRC-1:0] cmd_sel, lvl_sel, rse_sel, now_sel;
    logic               cmd_in, lvl_in, rse_in, now_in;
    logic [NUM_SRC-1:0] line_nxt;
    logic               line_rise;
    logic               rse_hard, now_hard;

    irq_idx_dec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dec_cmd (
        .vld(cmd_vld), .idx(cmd_idx), .sel(cmd_sel), .in_rng(cmd_in));
    irq_idx_dec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dec_lvl (
        .vld(lvl_vld), .idx(lvl_idx), .sel(lvl_sel), .in_rng(lvl_in));
    irq_idx_dec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dec_rse (
        .vld(raise_vld), .idx(raise_idx), .sel(rse_sel), .in_rng(rse_in));
    irq_idx_dec #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_dec_now (
        .vld(raise_now_vld), .idx(raise_now_idx), .sel(now_sel), .in_rng(now_in));

    irq_line_edge #(.NUM_SRC(NUM_SRC)) u_edge (
        .line_q(st_q.line), .sel(lvl_sel), .up(lvl_up),
        .line_nxt(line_nxt), .rise(line_rise));

    assign rse_hard = raise_vld && (raise_idx == HARD_SEL);
    assign now_hard = raise_now_vld && (raise_now_idx == HARD_SEL);

    always_comb begin
        st_d   = st_q;
        wake_d = 1'b0;

        // scheduled pulse wake from the previous cycle
        if (st_q.sched && (!st_q.lock || st_q.bypass)) begin
            wake_d      = 1'b1;
            st_d.bypass = 1'b0;
        end
        st_d.sched = 1'b0;

        // software command
        if (cmd_vld) begin
            unique case (irq_op_e'(cmd_op))
                OP_EN: begin
                    st_d.en = st_d.en | cmd_sel;
                    if (|(st_d.pend & cmd_sel)) begin
                        st_d.stat = st_d.stat | cmd_sel;
                        if (!st_d.lock) wake_d = 1'b1;
                    end
                end
                OP_DIS:    st_d.en = st_d.en & ~cmd_sel;
                OP_CLR1: begin
                    st_d.stat = st_d.stat & ~cmd_sel;
                    st_d.pend = st_d.pend & ~cmd_sel;
                end
                OP_CLREN: begin
                    st_d.stat = '0;
                    st_d.pend = st_d.pend & ~st_d.en;
                end
                OP_CLRALL: begin
                    st_d.stat = '0;
                    st_d.pend = '0;
                end
                OP_LOCK: begin
                    if (st_d.lock && !cmd_idx[0] && (|st_d.stat)) wake_d = 1'b1;
                    st_d.lock = cmd_idx[0];
                end
                OP_REEVAL: begin
                    if (|(st_d.line & cmd_sel)) begin
                        st_d.pend = st_d.pend | cmd_sel;
                        st_d.stat = st_d.stat | (cmd_sel & st_d.en);
                    end
                end
                default: ;
            endcase
        end

        // level line command
        st_d.line = line_nxt;
        st_d.err  = lvl_vld && !lvl_in;
        if (line_rise) begin
            st_d.pend = st_d.pend | lvl_sel;
            st_d.stat = st_d.stat | (lvl_sel & st_d.en);
            if (!st_d.lock || st_d.bypass) st_d.sched = 1'b1;
        end

        // pulse raise, wake one cycle later
        if (rse_in) begin
            st_d.pend = st_d.pend | rse_sel;
            st_d.stat = st_d.stat | (rse_sel & st_d.en);
        end
        if (rse_hard) st_d.bypass = 1'b1;
        if ((rse_in || rse_hard) && (!st_d.lock || st_d.bypass)) st_d.sched = 1'b1;

        // immediate raise, wake in this cycle
        if (now_in) begin
            st_d.pend = st_d.pend | now_sel;
            st_d.stat = st_d.stat | (now_sel & st_d.en);
        end
        if (now_hard) st_d.bypass = 1'b1;
        if ((now_in || now_hard) && (!st_d.lock || st_d.bypass)) begin
            wake_d      = 1'b1;
            st_d.bypass = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o  = st_q.en;
    assign pend_o    = st_q.pend;
    assign status_o  = st_q.stat;
    assign lock_o    = st_q.lock;
    assign lvl_err_o = st_q.err;
    assign wake_o    = wake_d;
endmodule

// File: rtl/irq_pend_core_chk.sv
module irq_pend_core_chk #(
    parameter int NUM_SRC  = 64,
    parameter int IDX_W    = 7,
    parameter int HARD_IDX = 127
) (
    input logic               clk,
    input logic               rst_n,
    input logic               raise_vld,
    input logic               raise_now_vld,
    input logic               lvl_vld,
    input logic [IDX_W-1:0]   lvl_idx,
    input logic               cmd_vld,
    input logic [2:0]         cmd_op,
    input logic [IDX_W-1:0]   cmd_idx,
    input logic [NUM_SRC-1:0] pend_o,
    input logic [NUM_SRC-1:0] status_o,
    input logic               lock_o,
    input logic               wake_o,
    input logic               lvl_err_o
);
    localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(NUM_SRC);

    logic [NUM_SRC-1:0] cmd_bit;
    logic               cmd_ok, lvl_ok, quiet;

    always_comb begin
        cmd_bit = NUM_SRC'(1) << cmd_idx;
        cmd_ok  = cmd_vld && ({1'b0, cmd_idx} < LIMIT);
        lvl_ok  = ({1'b0, lvl_idx} < LIMIT);
        quiet   = !raise_vld && !raise_now_vld && !lvl_vld;
    end

    // R1
    stat_in_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~pend_o) == '0);

    // R2
    en_pended_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_op == 3'd1 && |(pend_o & cmd_bit) && !lock_o) |-> wake_o);

    // R3
    unlock_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == 3'd6 && !cmd_idx[0] && lock_o && |status_o) |-> wake_o);

    // R5
    clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok && cmd_op == 3'd3 && quiet) |=> ((pend_o | status_o) & $past(cmd_bit)) == '0);

    // R6
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == 3'd5 && quiet) |=> (pend_o == '0 && status_o == '0));

    // R11
    lvl_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_vld && !lvl_ok) |=> lvl_err_o);

    // R12
    disable_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld && cmd_op == 3'd2 && quiet) |=> ($stable(pend_o) && $stable(status_o)));
endmodule

bind irq_pend_core irq_pend_core_chk #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .HARD_IDX(HARD_IDX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .raise_vld(raise_vld), .raise_now_vld(raise_now_vld),
    .lvl_vld(lvl_vld), .lvl_idx(lvl_idx), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .pend_o(pend_o), .status_o(status_o), .lock_o(lock_o),
    .wake_o(wake_o), .lvl_err_o(lvl_err_o)
);

// File: tb/irq_pend_core_tb.sv
`timescale 1ns/1ps
module irq_pend_core_tb;
    localparam int NS = 64;
    localparam int IW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic raise_vld = 0, raise_now_vld = 0, lvl_vld = 0, lvl_up = 0, cmd_vld = 0;
    logic [IW-1:0] raise_idx = '0, raise_now_idx = '0, lvl_idx = '0, cmd_idx = '0;
    logic [2:0] cmd_op = '0;
    logic [NS-1:0] enable_o, pend_o, status_o;
    logic lock_o, wake_o, lvl_err_o;

    int n_checks = 0;
    int n_fail = 0;

    // reference model state
    bit [63:0] m_en, m_pend, m_stat, m_line;
    bit m_lock, m_byp, m_sched, m_err;
    bit [63:0] n_en, n_pend, n_stat, n_line;
    bit n_lock, n_byp, n_sched, n_err, e_wake;

    always #2.5 clk = ~clk;

    irq_pend_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .raise_vld(raise_vld), .raise_idx(raise_idx),
        .raise_now_vld(raise_now_vld), .raise_now_idx(raise_now_idx),
        .lvl_vld(lvl_vld), .lvl_up(lvl_up), .lvl_idx(lvl_idx),
        .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .enable_o(enable_o), .pend_o(pend_o), .status_o(status_o),
        .lock_o(lock_o), .wake_o(wake_o), .lvl_err_o(lvl_err_o)
    );

    function automatic bit [63:0] bitof(input int i);
        return (i < NS) ? (64'd1 << i) : 64'd0;
    endfunction

    task automatic pend_src(input int i);
        n_pend |= bitof(i);
        n_stat |= bitof(i) & n_en;
    endtask

    task automatic model_eval();
        int ci, li, ri, ni;
        ci = cmd_idx; li = lvl_idx; ri = raise_idx; ni = raise_now_idx;
        n_en = m_en; n_pend = m_pend; n_stat = m_stat; n_line = m_line;
        n_lock = m_lock; n_byp = m_byp; n_sched = 0; e_wake = 0;
        if (m_sched && (!m_lock || m_byp)) begin e_wake = 1; n_byp = 0; end
        if (cmd_vld) begin
            case (cmd_op)
                3'd1: if (ci < NS) begin
                    n_en |= bitof(ci);
                    if ((n_pend & bitof(ci)) != 0) begin
                        n_stat |= bitof(ci);
                        if (!n_lock) e_wake = 1;
                    end
                end
                3'd2: n_en &= ~bitof(ci);
                3'd3: begin n_stat &= ~bitof(ci); n_pend &= ~bitof(ci); end
                3'd4: begin n_stat = 0; n_pend &= ~n_en; end
                3'd5: begin n_stat = 0; n_pend = 0; end
                3'd6: begin
                    if (n_lock && !cmd_idx[0] && n_stat != 0) e_wake = 1;
                    n_lock = cmd_idx[0];
                end
                3'd7: if ((n_line & bitof(ci)) != 0) pend_src(ci);
                default: ;
            endcase
        end
        n_err = lvl_vld && (li >= NS);
        if (lvl_vld && li < NS) begin
            if (!lvl_up) n_line &= ~bitof(li);
            else if ((n_line & bitof(li)) == 0) begin
                n_line |= bitof(li);
                pend_src(li);
                if (!n_lock || n_byp) n_sched = 1;
            end
        end
        if (raise_vld) begin
            if (ri < NS) pend_src(ri);
            if (ri == 127) n_byp = 1;
            if ((ri < NS || ri == 127) && (!n_lock || n_byp)) n_sched = 1;
        end
        if (raise_now_vld) begin
            if (ni < NS) pend_src(ni);
            if (ni == 127) n_byp = 1;
            if ((ni < NS || ni == 127) && (!n_lock || n_byp)) begin e_wake = 1; n_byp = 0; end
        end
    endtask

    task automatic tick(input string tag);
        model_eval();
        @(negedge clk);
        n_checks++;
        if (status_o !== m_stat || pend_o !== m_pend || enable_o !== m_en ||
            lock_o !== m_lock || wake_o !== e_wake || lvl_err_o !== m_err) begin
            n_fail++;
            $display("FAIL %s: actual stat=%h pend=%h en=%h lock=%b wake=%b err=%b expected stat=%h pend=%h en=%h lock=%b wake=%b err=%b",
                     tag, status_o, pend_o, enable_o, lock_o, wake_o, lvl_err_o,
                     m_stat, m_pend, m_en, m_lock, e_wake, m_err);
        end
        @(posedge clk);
        m_en = n_en; m_pend = n_pend; m_stat = n_stat; m_line = n_line;
        m_lock = n_lock; m_byp = n_byp; m_sched = n_sched; m_err = n_err;
        #1;
        raise_vld = 0; raise_now_vld = 0; lvl_vld = 0; cmd_vld = 0;
    endtask

    task automatic do_raise(input int i, input string tag);
        raise_vld = 1; raise_idx = IW'(i); tick(tag);
    endtask
    task automatic do_now(input int i, input string tag);
        raise_now_vld = 1; raise_now_idx = IW'(i); tick(tag);
    endtask
    task automatic do_cmd(input int op, input int i, input string tag);
        cmd_vld = 1; cmd_op = 3'(op); cmd_idx = IW'(i); tick(tag);
    endtask
    task automatic do_lvl(input bit up, input int i, input string tag);
        lvl_vld = 1; lvl_up = up; lvl_idx = IW'(i); tick(tag);
    endtask
    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) tick(tag);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual run still active, expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        m_en = 0; m_pend = 0; m_stat = 0; m_line = 0;
        m_lock = 0; m_byp = 0; m_sched = 0; m_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (enable_o !== 0 || pend_o !== 0 || status_o !== 0 || lock_o !== 0 || wake_o !== 0) begin
            n_fail++;
            $display("FAIL R10: actual en=%h pend=%h stat=%h lock=%b wake=%b expected all 0",
                     enable_o, pend_o, status_o, lock_o, wake_o);
        end
        rst_n = 1;
        @(posedge clk); #1;
        idle(2, "R10");

        // R4: pulse raise on a disabled source, wake next cycle
        do_raise(3, "R4");
        idle(2, "R4");
        // R2: enabling a pended source pends status and wakes now
        do_cmd(1, 3, "R2");
        // R1: raise on enabled and on disabled sources
        do_cmd(1, 5, "R1");
        idle(1, "R1");
        do_raise(5, "R1");
        do_raise(6, "R1");
        idle(1, "R1");
        // R4: immediate raise wakes in same cycle
        do_now(11, "R4");
        // R5: clear one source
        do_cmd(3, 3, "R5");
        // R12: disable keeps pending vectors, nop changes nothing
        do_cmd(2, 5, "R12");
        do_cmd(0, 5, "R12");
        // R3: lock defers wake, unlock with status nonzero wakes
        do_cmd(6, 1, "R3");
        do_raise(9, "R3");
        idle(2, "R3");
        do_cmd(1, 9, "R3");
        do_now(20, "R3");
        do_cmd(6, 0, "R3");
        idle(1, "R3");
        // R9: hard request bypasses the lock once
        do_cmd(6, 1, "R9");
        do_raise(127, "R9");
        idle(1, "R9");
        do_raise(10, "R9");
        idle(2, "R9");
        do_now(127, "R9");
        do_now(12, "R9");
        do_cmd(6, 0, "R9");
        // R7: level lines pend on rising change only
        do_cmd(5, 0, "R6");
        do_lvl(1, 30, "R7");
        idle(1, "R7");
        do_cmd(3, 30, "R7");
        do_lvl(1, 30, "R7");
        idle(1, "R7");
        do_lvl(0, 30, "R7");
        do_lvl(1, 30, "R7");
        idle(1, "R7");
        // R8: handler-exit re-evaluation
        do_cmd(1, 40, "R8");
        do_lvl(1, 40, "R8");
        do_cmd(3, 40, "R8");
        do_cmd(7, 40, "R8");
        do_cmd(3, 40, "R8");
        do_lvl(0, 40, "R8");
        do_cmd(7, 40, "R8");
        do_cmd(7, 30, "R8");
        // R6: clear enabled only, then clear all
        do_raise(63, "R6");
        do_raise(0, "R6");
        do_cmd(1, 63, "R6");
        do_cmd(4, 0, "R6");
        idle(1, "R6");
        do_cmd(5, 0, "R6");
        // R11: out-of-range indices ignored, level error flag
        do_raise(70, "R11");
        do_now(100, "R11");
        do_cmd(1, 64, "R11");
        do_lvl(1, 64, "R11");
        idle(1, "R11");
        do_lvl(1, 127, "R11");
        idle(1, "R11");
        // ordering within one cycle: command then raise
        cmd_vld = 1; cmd_op = 3'd1; cmd_idx = IW'(50);
        raise_vld = 1; raise_idx = IW'(50);
        tick("R1");
        idle(2, "R1");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule